// File: doc/BRIEF.md
# Maskable Two-Output Alert Aggregator

This block gathers error bits from a set of sticky status groups and turns them into two active-low alert requests, each modelled as a pull-down enable for an open-drain pad (1 means the pad is pulled low). Each alert output owns a private bank of mask words, one word per status group. A mask bit of 1 blocks the matching error bit, and a mask bit of 0 lets it through. Every mask bit powers up set, so no alert can fire until the host clears mask bits.

The block also drives a top-level summary byte with one bit per status group. A group's summary bit is set only by an error that at least one of the two outputs leaves unmasked. A fully masked error therefore stays out of the summary as well as off the pins.

The host updates masks through a write port. Each write carries a bank command code, a status-group address and a 16-bit mask word. A separate setup write chooses which stored mask word appears on the read-back port. The second output also has a driver enable that resets to off. Sticky status bits are set by error pulses and cleared through a write-one-to-clear port.

Top module: `alert_agg`

## Requirements
- R1: After reset, both alert outputs are 0, the summary is 0, the second-output driver enable is 0, and every mask word in both banks reads back as 16'hFFFF.
- R2: An error bit raises an alert output only while its mask bit in that output's bank is 0. The output rises at the second rising edge after the error pulse is sampled.
- R3: Summary bit g (bit position g = group index) is 1 exactly when group g holds a set status bit whose mask bit is 0 in at least one bank. When the summary is all zero, both alert outputs are 0 one cycle later.
- R4: A mask write takes effect only when its command is CMD_A1 (8'h1B, first bank) or CMD_A2 (8'hDF, second bank) and its address lies in STAT_BASE .. STAT_BASE+N_GRP-1 (group = address − STAT_BASE). Any other command or address changes no mask word.
- R5: A read setup with a valid command and address makes rd_mask show that bank's stored word for that group from the next cycle on. A setup with an invalid command or address leaves the previous selection in place.
- R6: While the second-output driver enable is 0, alert2_pd is 0 whatever the status and masks are.
- R7: Status bits are sticky. They stay set after the error pulse until they are cleared through the clear port. An alert drops at the edge after the edge that clears its last unmasked error bit.
- R8: When an error pulse and a clear hit the same status bit in the same cycle, the bit ends up set.
- R9: Each alert output is the OR over all groups of (status AND NOT mask). An unmasked error in any single group asserts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| err_set | input | N_GRP*16 | Error pulses; group g occupies bits [16g+15:16g] |
| clr_we | input | 1 | Status clear strobe |
| clr_addr | input | 8 | Status group address to clear |
| clr_bits | input | 16 | Write-one-to-clear bits |
| mask_we | input | 1 | Mask write strobe |
| mask_cmd | input | 8 | Bank command code |
| mask_addr | input | 8 | Status group address of the mask |
| mask_bits | input | 16 | New mask word |
| rd_we | input | 1 | Read-back selection strobe |
| rd_cmd | input | 8 | Bank command code to read |
| rd_addr | input | 8 | Status group address to read |
| rd_mask | output | 16 | Selected mask word |
| cfg_we | input | 1 | Driver-enable write strobe |
| cfg_oe2 | input | 1 | Driver enable for the second output |
| alert1_pd | output | 1 | First output pull-down enable |
| alert2_pd | output | 1 | Second output pull-down enable |
| summary | output | N_GRP | Per-group summary bits |

## Verification
The hardest case to reach is an error that is masked in one bank and unmasked in the other. In that case the summary bit and exactly one pin must follow the error, with the second pin's driver enable added on top. The vector table writes different mask words into the two banks for the same group, fires one error bit, and checks both pins and the summary together. It then restores full masking and clears the group before the next vector. Directed tests cover a pulse that lands together with a clear, and the one-cycle lag between a clear and the alert's release.

// File: rtl/alert_agg_pkg.sv
package alert_agg_pkg;
   typedef enum logic { BANK_A1 = 1'b0, BANK_A2 = 1'b1 } bank_e;
   localparam int unsigned N_BANK = 2;
endpackage

// File: rtl/alert_status_regs.sv
module alert_status_regs #(
   parameter int unsigned N_GRP     = 4,
   parameter int unsigned MASK_W    = 16,
   parameter int unsigned ADDR_W    = 8,
   parameter int unsigned STAT_BASE = 8'h40
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [N_GRP*MASK_W-1:0]   err_set,
   input  logic                      clr_we,
   input  logic [ADDR_W-1:0]         clr_addr,
   input  logic [MASK_W-1:0]         clr_bits,
   output logic [N_GRP*MASK_W-1:0]   stat_q
);
   localparam logic [ADDR_W-1:0] BASE = ADDR_W'(STAT_BASE);

   logic [ADDR_W-1:0] clr_off;
   logic              clr_hit;
   assign clr_off = clr_addr - BASE;
   assign clr_hit = clr_we && (clr_addr >= BASE) && (clr_off < ADDR_W'(N_GRP));

   for (genvar g = 0; g < N_GRP; g++) begin : g_grp
      logic [MASK_W-1:0] clr_mask;
      assign clr_mask = (clr_hit && clr_off == ADDR_W'(g)) ? clr_bits : '0;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            stat_q[g*MASK_W +: MASK_W] <= '0;
         else
            stat_q[g*MASK_W +: MASK_W] <= (stat_q[g*MASK_W +: MASK_W] & ~clr_mask)
                                          | err_set[g*MASK_W +: MASK_W];
      end
   end
endmodule

// File: rtl/alert_mask_bank.sv
module alert_mask_bank #(
   parameter int unsigned N_GRP     = 4,
   parameter int unsigned MASK_W    = 16,
   parameter int unsigned ADDR_W    = 8,
   parameter int unsigned STAT_BASE = 8'h40,
   parameter logic [7:0]  CMD       = 8'h1B
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      wr_we,
   input  logic [7:0]                wr_cmd,
   input  logic [ADDR_W-1:0]         wr_addr,
   input  logic [MASK_W-1:0]         wr_bits,
   input  logic [N_GRP*MASK_W-1:0]   stat_q,
   output logic [N_GRP*MASK_W-1:0]   mask_q,
   output logic [N_GRP-1:0]          grp_live,
   output logic                      alert_q
);
   localparam logic [ADDR_W-1:0] BASE = ADDR_W'(STAT_BASE);

   logic [ADDR_W-1:0] wr_off;
   logic              wr_hit;
   assign wr_off = wr_addr - BASE;
   assign wr_hit = wr_we && (wr_cmd == CMD) && (wr_addr >= BASE)
                   && (wr_off < ADDR_W'(N_GRP));

   for (genvar g = 0; g < N_GRP; g++) begin : g_word
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            mask_q[g*MASK_W +: MASK_W] <= '1;
         else if (wr_hit && wr_off == ADDR_W'(g))
            mask_q[g*MASK_W +: MASK_W] <= wr_bits;
      end
      assign grp_live[g] = |(stat_q[g*MASK_W +: MASK_W] & ~mask_q[g*MASK_W +: MASK_W]);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) alert_q <= 1'b0;
      else        alert_q <= |grp_live;
   end
endmodule

// File: rtl/alert_agg.sv
module alert_agg
   import alert_agg_pkg::*;
#(
   parameter int unsigned N_GRP     = 4,
   parameter int unsigned MASK_W    = 16,
   parameter int unsigned ADDR_W    = 8,
   parameter int unsigned STAT_BASE = 8'h40,
   parameter logic [7:0]  CMD_A1    = 8'h1B,
   parameter logic [7:0]  CMD_A2    = 8'hDF
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [N_GRP*MASK_W-1:0]   err_set,
   input  logic                      clr_we,
   input  logic [ADDR_W-1:0]         clr_addr,
   input  logic [MASK_W-1:0]         clr_bits,
   input  logic                      mask_we,
   input  logic [7:0]                mask_cmd,
   input  logic [ADDR_W-1:0]         mask_addr,
   input  logic [MASK_W-1:0]         mask_bits,
   input  logic                      rd_we,
   input  logic [7:0]                rd_cmd,
   input  logic [ADDR_W-1:0]         rd_addr,
   output logic [MASK_W-1:0]         rd_mask,
   input  logic                      cfg_we,
   input  logic                      cfg_oe2,
   output logic                      alert1_pd,
   output logic                      alert2_pd,
   output logic [N_GRP-1:0]          summary
);
   localparam logic [ADDR_W-1:0] BASE = ADDR_W'(STAT_BASE);

   initial begin
      assert (N_GRP >= 1 && N_GRP <= 8) else $error("N_GRP out of range");
      assert (STAT_BASE + N_GRP <= (1 << ADDR_W)) else $error("status window exceeds address space");
      assert (CMD_A1 != CMD_A2) else $error("bank commands must differ");
      assert (MASK_W >= 1) else $error("MASK_W must be positive");
   end

   logic [N_GRP*MASK_W-1:0] stat_q;
   logic [N_GRP*MASK_W-1:0] bank_mask [N_BANK];
   logic [N_GRP-1:0]        bank_live [N_BANK];
   logic [N_BANK-1:0]       bank_alert;
   logic                    oe2_q;

   alert_status_regs #(
      .N_GRP(N_GRP), .MASK_W(MASK_W), .ADDR_W(ADDR_W), .STAT_BASE(STAT_BASE)
   ) u_status (
      .clk(clk), .rst_n(rst_n), .err_set(err_set),
      .clr_we(clr_we), .clr_addr(clr_addr), .clr_bits(clr_bits),
      .stat_q(stat_q)
   );

   for (genvar b = 0; b < N_BANK; b++) begin : g_bank
      localparam logic [7:0] BCMD = (b == 0) ? CMD_A1 : CMD_A2;
      alert_mask_bank #(
         .N_GRP(N_GRP), .MASK_W(MASK_W), .ADDR_W(ADDR_W),
         .STAT_BASE(STAT_BASE), .CMD(BCMD)
      ) u_bank (
         .clk(clk), .rst_n(rst_n),
         .wr_we(mask_we), .wr_cmd(mask_cmd), .wr_addr(mask_addr), .wr_bits(mask_bits),
         .stat_q(stat_q), .mask_q(bank_mask[b]), .grp_live(bank_live[b]),
         .alert_q(bank_alert[b])
      );
   end

   assign summary = bank_live[0] | bank_live[1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      oe2_q <= 1'b0;
      else if (cfg_we) oe2_q <= cfg_oe2;
   end

   assign alert1_pd = bank_alert[0];
   assign alert2_pd = bank_alert[1] & oe2_q;

   // read-back selection
   bank_e             sel_bank;
   logic [ADDR_W-1:0] sel_off;
   logic [ADDR_W-1:0] rd_off;
   logic              rd_cmd_ok;
   logic              rd_hit;
   assign rd_off    = rd_addr - BASE;
   assign rd_cmd_ok = (rd_cmd == CMD_A1) || (rd_cmd == CMD_A2);
   assign rd_hit    = rd_we && rd_cmd_ok && (rd_addr >= BASE) && (rd_off < ADDR_W'(N_GRP));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_bank <= BANK_A1;
         sel_off  <= '0;
      end else if (rd_hit) begin
         sel_bank <= (rd_cmd == CMD_A2) ? BANK_A2 : BANK_A1;
         sel_off  <= rd_off;
      end
   end

   always_comb begin
      rd_mask = '1;
      for (int g = 0; g < N_GRP; g++) begin
         if (sel_off == ADDR_W'(g))
            rd_mask = (sel_bank == BANK_A2) ? bank_mask[1][g*MASK_W +: MASK_W]
                                            : bank_mask[0][g*MASK_W +: MASK_W];
      end
   end
endmodule

// File: rtl/alert_agg_checker.sv
module alert_agg_checker #(
   parameter int unsigned N_GRP  = 4,
   parameter int unsigned MASK_W = 16
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic [N_GRP*MASK_W-1:0] err_set,
   input logic [N_GRP*MASK_W-1:0] stat_q,
   input logic                    cfg_we,
   input logic                    cfg_oe2,
   input logic                    alert1_pd,
   input logic                    alert2_pd,
   input logic [N_GRP-1:0]        summary
);
   AST_OE2_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && !cfg_oe2) |=> !alert2_pd); // R6
   AST_QUIET_SUMMARY: assert property (@(posedge clk) disable iff (!rst_n)
      (summary == '0) |=> (!alert1_pd && !alert2_pd)); // R3
   AST_ALERT_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
      alert1_pd |-> $past(summary != '0)); // R9
   AST_PULSE_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
      (err_set != '0) |=> ((stat_q & $past(err_set)) == $past(err_set))); // R8
   AST_ALERT2_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
      alert2_pd |-> $past(summary != '0)); // R2
endmodule

bind alert_agg alert_agg_checker #(.N_GRP(N_GRP), .MASK_W(MASK_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .err_set(err_set), .stat_q(stat_q),
   .cfg_we(cfg_we), .cfg_oe2(cfg_oe2),
   .alert1_pd(alert1_pd), .alert2_pd(alert2_pd), .summary(summary)
);

// File: tb/alert_agg_bench.sv
module alert_agg_bench;
   localparam int CLK_PERIOD = 10;
   localparam int NG = 4;
   localparam int MW = 16;
   localparam logic [7:0] BASE = 8'h40;
   localparam logic [7:0] C1 = 8'h1B;
   localparam logic [7:0] C2 = 8'hDF;

   typedef struct packed {
      logic [1:0]  grp;
      logic [3:0]  bitn;
      logic [15:0] m1;
      logic [15:0] m2;
      logic        oe;
      logic        e_a1;
      logic        e_a2;
      logic [3:0]  e_sum;
   } vec_t;

   localparam vec_t VECS [6] = '{
      '{2'd0, 4'd0,  16'hFFFE, 16'hFFFF, 1'b0, 1'b1, 1'b0, 4'b0001},
      '{2'd1, 4'd5,  16'hFFFF, 16'hFFDF, 1'b1, 1'b0, 1'b1, 4'b0010},
      '{2'd2, 4'd5,  16'hFFFF, 16'hFFDF, 1'b0, 1'b0, 1'b0, 4'b0100},
      '{2'd3, 4'd15, 16'hFFFF, 16'hFFFF, 1'b1, 1'b0, 1'b0, 4'b0000},
      '{2'd3, 4'd15, 16'h7FFF, 16'h7FFF, 1'b1, 1'b1, 1'b1, 4'b1000},
      '{2'd0, 4'd3,  16'hFFFB, 16'hFFFF, 1'b1, 1'b0, 1'b0, 4'b0000}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [NG*MW-1:0] err_set = '0;
   logic clr_we = 1'b0;
   logic [7:0] clr_addr = '0;
   logic [15:0] clr_bits = '0;
   logic mask_we = 1'b0;
   logic [7:0] mask_cmd = '0;
   logic [7:0] mask_addr = '0;
   logic [15:0] mask_bits = '0;
   logic rd_we = 1'b0;
   logic [7:0] rd_cmd = '0;
   logic [7:0] rd_addr = '0;
   logic [15:0] rd_mask;
   logic cfg_we = 1'b0;
   logic cfg_oe2 = 1'b0;
   logic alert1_pd, alert2_pd;
   logic [NG-1:0] summary;

   int n_chk = 0;
   int n_err = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   alert_agg u_alert_agg (
      .clk(clk), .rst_n(rst_n), .err_set(err_set),
      .clr_we(clr_we), .clr_addr(clr_addr), .clr_bits(clr_bits),
      .mask_we(mask_we), .mask_cmd(mask_cmd), .mask_addr(mask_addr), .mask_bits(mask_bits),
      .rd_we(rd_we), .rd_cmd(rd_cmd), .rd_addr(rd_addr), .rd_mask(rd_mask),
      .cfg_we(cfg_we), .cfg_oe2(cfg_oe2),
      .alert1_pd(alert1_pd), .alert2_pd(alert2_pd), .summary(summary)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic tick(); @(negedge clk); endtask

   task automatic wr_mask(input logic [7:0] cmd, input logic [7:0] addr, input logic [15:0] bits);
      mask_we = 1'b1; mask_cmd = cmd; mask_addr = addr; mask_bits = bits;
      tick();
      mask_we = 1'b0;
   endtask

   task automatic sel_rd(input logic [7:0] cmd, input logic [7:0] addr);
      rd_we = 1'b1; rd_cmd = cmd; rd_addr = addr;
      tick();
      rd_we = 1'b0;
   endtask

   task automatic set_oe(input logic v);
      cfg_we = 1'b1; cfg_oe2 = v;
      tick();
      cfg_we = 1'b0;
   endtask

   task automatic pulse(input int g, input int b);
      err_set = '0; err_set[g*MW + b] = 1'b1;
      tick();
      err_set = '0;
   endtask

   task automatic clear(input logic [7:0] addr, input logic [15:0] bits);
      clr_we = 1'b1; clr_addr = addr; clr_bits = bits;
      tick();
      clr_we = 1'b0;
   endtask

   initial begin
      #(CLK_PERIOD * 20000);
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      tick(); tick();
      // R1 reset state
      check("R1 alert1", alert1_pd, 0);
      check("R1 alert2", alert2_pd, 0);
      check("R1 summary", summary, 0);
      check("R1 rd_mask", rd_mask, 16'hFFFF);
      rst_n = 1'b1;
      tick();
      sel_rd(C2, BASE + 8'd3);
      check("R1 bank2 mask", rd_mask, 16'hFFFF);

      // vector table: R2 R3 R6 R9
      foreach (VECS[i]) begin
         set_oe(VECS[i].oe);
         wr_mask(C1, BASE + 8'(VECS[i].grp), VECS[i].m1);
         wr_mask(C2, BASE + 8'(VECS[i].grp), VECS[i].m2);
         pulse(VECS[i].grp, VECS[i].bitn);
         check($sformatf("R3 summary v%0d", i), summary, VECS[i].e_sum);
         tick();
         check($sformatf("R2 R9 alert1 v%0d", i), alert1_pd, VECS[i].e_a1);
         check($sformatf("R6 alert2 v%0d", i), alert2_pd, VECS[i].e_a2);
         wr_mask(C1, BASE + 8'(VECS[i].grp), 16'hFFFF);
         wr_mask(C2, BASE + 8'(VECS[i].grp), 16'hFFFF);
         clear(BASE + 8'(VECS[i].grp), 16'hFFFF);
         tick();
         check($sformatf("R2 idle v%0d", i), {alert1_pd, alert2_pd}, 0);
      end

      // R5 read-back
      wr_mask(C1, BASE + 8'd2, 16'h1234);
      sel_rd(C1, BASE + 8'd2);
      check("R5 read bank1 g2", rd_mask, 16'h1234);
      sel_rd(C2, BASE + 8'd2);
      check("R5 read bank2 g2", rd_mask, 16'hFFFF);
      sel_rd(C1, BASE + 8'd9);
      check("R5 bad setup keeps sel", rd_mask, 16'hFFFF);
      sel_rd(8'h55, BASE + 8'd2);
      check("R5 bad cmd keeps sel", rd_mask, 16'hFFFF);

      // R4 ignored writes
      wr_mask(8'h55, BASE, 16'h0000);
      wr_mask(C1, BASE + 8'd4, 16'h0000);
      wr_mask(C1, BASE - 8'd1, 16'h0000);
      sel_rd(C1, BASE);
      check("R4 bad cmd ignored", rd_mask, 16'hFFFF);
      sel_rd(C2, BASE);
      check("R4 bank2 untouched", rd_mask, 16'hFFFF);
      sel_rd(C1, BASE + 8'd3);
      check("R4 out of range ignored", rd_mask, 16'hFFFF);
      wr_mask(C2, BASE + 8'd3, 16'h00F0);
      sel_rd(C1, BASE + 8'd3);
      check("R4 bank1 not hit by bank2 write", rd_mask, 16'hFFFF);
      sel_rd(C2, BASE + 8'd3);
      check("R4 bank2 write lands", rd_mask, 16'h00F0);
      wr_mask(C2, BASE + 8'd3, 16'hFFFF);

      // R7 sticky and release timing
      wr_mask(C1, BASE + 8'd1, 16'hFFFE);
      pulse(1, 0);
      for (int k = 0; k < 8; k++) tick();
      check("R7 sticky alert1", alert1_pd, 1);
      clear(BASE + 8'd1, 16'h0001);
      check("R7 alert1 one cycle after clear", alert1_pd, 1);
      check("R7 summary cleared", summary, 0);
      tick();
      check("R7 alert1 released", alert1_pd, 0);

      // R8 set wins over clear
      err_set = '0; err_set[1*MW + 0] = 1'b1;
      clr_we = 1'b1; clr_addr = BASE + 8'd1; clr_bits = 16'hFFFF;
      tick();
      err_set = '0; clr_we = 1'b0;
      check("R8 summary stays set", summary, 4'b0010);
      tick();
      check("R8 alert1 set", alert1_pd, 1);
      clear(BASE + 8'd1, 16'hFFFF);
      tick();

      // R6 driver disable with live error
      set_oe(1'b1);
      wr_mask(C2, BASE, 16'hFFFE);
      pulse(0, 0);
      tick();
      check("R6 alert2 enabled", alert2_pd, 1);
      set_oe(1'b0);
      check("R6 alert2 gated", alert2_pd, 0);

      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule